// File: doc/BRIEF.md
# Register and Y-Memory Parallel Move Unit

This block performs the data move that travels alongside a data ALU operation: register traffic between the accumulators and the ALU input registers, plus one word to or from Y memory. It also checks that the move is legal before any state is touched. The decoder hands it a decoded instruction: the move class, the register codes, the direction, an addressing-mode tag, an effective address, an immediate word, and which accumulator the ALU operation itself writes. The block takes snapshots of the register file contents it needs, fetches from Y memory when required, and then drives write enables and data back to the register file and to memory. It raises an illegal-instruction flag in place of any writes when the move breaks a rule.

Each instruction runs through a small controller. Its states are `ST_IDLE`, `ST_FETCH`, `ST_COMMIT` and `ST_FAULT`. The transitions are:

- `ST_IDLE` to `ST_FETCH` on a legal issue.
- `ST_IDLE` to `ST_FAULT` on an illegal issue.
- `ST_FETCH` to `ST_COMMIT` always.
- `ST_COMMIT` to `ST_IDLE` always.
- `ST_FAULT` to `ST_IDLE` always.

Register codes are 4 bits. Bits 3:2 select the group: 0 for the input registers, 1 for accumulator A, 2 for accumulator B, and 3 is invalid. Bits 1:0 select within the group. For the input registers these are X0=0, X1=1, Y0=2 and Y1=3. For an accumulator they are the low word=0, the high word=1, the extension=2 and the whole accumulator=3.

Top module: `pmove_unit`

## Requirements
- R1: Class I (`class2_i`=0) copies the high word (bits 47:24) of the accumulator picked by `acc_src_i` (0=A, 1=B) into the input register `ireg_dst_i`. Issue is sampled at edge n and the write is driven between edges n+1 and n+2. The next instruction therefore reads the new value.
- R2: A Class I load (`ystore_i`=0) with a memory addressing mode raises `y_re_o` with `y_addr_o`=`ea_i` between edges n and n+1. It writes `y_rdata_i` to the register coded by `yreg_i` during the commit cycle.
- R3: A Class I store (`ystore_i`=1) writes the register coded by `yreg_i` to Y memory at `ea_i`, taking the value the register held at issue. An extension part is read sign-extended to 24 bits. A whole accumulator is read as its high word.
- R4: Addressing-mode tag 7 selects long immediate: a load takes `imm_i` and performs no memory read. A Class I store with tag 7 is illegal.
- R5: Class I accepts every addressing-mode tag 0 to 7, including 5 (short absolute) and 6 (long absolute).
- R6: Class II (`class2_i`=1) stores the pre-instruction high word of the accumulator `acc_src_i` to Y memory at `ea_i`. The same accumulator receives the pre-instruction Y0 as a whole-accumulator word.
- R7: Class II with addressing-mode tag 6 or 7 is illegal.
- R8: Bit 0 of `alu_dst_i` means the ALU writes A, and bit 1 means it writes B. A move destination that is that accumulator or any part of it is illegal. Storing from that accumulator stays legal.
- R9: On an illegal issue, `illegal_o` is high for exactly the one cycle after the issue edge. No register write, memory write or memory read occurs for that instruction.
- R10: A whole-accumulator write of a 24-bit word places the word in bits 47:24, fills bits 55:48 with its sign and clears bits 23:0. A part write changes only that part; an extension write takes the word's low 8 bits.
- R11: A Class I register code whose group bits are 3 (codes 12 to 15) is illegal.
- R12: When the Class I Y-side load and the accumulator copy name the same input register, the Y-side value is written.
- R13: `issue_i` is ignored while an instruction is in progress.
- R14: After reset, all write enables, `y_re_o` and `illegal_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue_i | input | 1 | Decoded instruction valid |
| class2_i | input | 1 | 0 = Class I, 1 = Class II |
| acc_src_i | input | 1 | Source accumulator (Class I) or moved accumulator (Class II), 0=A 1=B |
| ireg_dst_i | input | 2 | Class I accumulator-copy destination input register |
| ystore_i | input | 1 | Class I Y direction: 1 register to memory, 0 memory/immediate to register |
| yreg_i | input | 4 | Class I Y-side register code |
| amode_i | input | AMODE_W | Addressing-mode tag |
| ea_i | input | AW | Effective address |
| imm_i | input | DW | Long immediate word |
| alu_dst_i | input | 2 | Accumulators written by the ALU operation (bit0 A, bit1 B) |
| x0_i | input | DW | Current X0 |
| x1_i | input | DW | Current X1 |
| y0_i | input | DW | Current Y0 |
| y1_i | input | DW | Current Y1 |
| acc_a_i | input | EXT_W+2*DW | Current accumulator A |
| acc_b_i | input | EXT_W+2*DW | Current accumulator B |
| y_rdata_i | input | DW | Y memory read data, valid the cycle after `y_re_o` |
| ireg_we_o | output | 4 | Input register write enables (bit i = register i) |
| ireg_wdata_o | output | 4*DW | Input register write data, slot i at bits i*DW |
| acc_we_o | output | 2 | Accumulator write enables (bit0 A, bit1 B) |
| acc_part_o | output | 3 | Parts written (bit0 low, bit1 high, bit2 extension) |
| acc_wdata_o | output | EXT_W+2*DW | Accumulator write data, already placed |
| y_re_o | output | 1 | Y memory read strobe |
| y_we_o | output | 1 | Y memory write strobe |
| y_addr_o | output | AW | Y memory address |
| y_wdata_o | output | DW | Y memory write data |
| illegal_o | output | 1 | Illegal-instruction flag |

## Verification
The bench overrides the address width to 8 and keeps the 24-bit word, the 8-bit extension and addressing-mode tags 6 and 7. With those values, a behavioural Y memory of 256 words covers every address the unit can drive, so any misdirected store shows up as a changed word at a known location. The bench also models the register file from the write outputs, so the visibility of one instruction's results to the next can be observed. Its addressing tags are the defaults, which brings both long-mode rejections and the immediate path within reach.

// File: rtl/pmove_pkg.sv
package pmove_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_COMMIT,
        ST_FAULT
    } pm_state_e;

    localparam logic [1:0] GRP_IREG = 2'd0;
    localparam logic [1:0] GRP_ACCA = 2'd1;
    localparam logic [1:0] GRP_ACCB = 2'd2;
    localparam logic [1:0] GRP_BAD  = 2'd3;

    localparam logic [1:0] PART_LO    = 2'd0;
    localparam logic [1:0] PART_HI    = 2'd1;
    localparam logic [1:0] PART_EXT   = 2'd2;
    localparam logic [1:0] PART_WHOLE = 2'd3;

    function automatic logic [2:0] part_mask(input logic [1:0] part);
        logic [2:0] m;
        unique case (part)
            PART_LO:    m = 3'b001;
            PART_HI:    m = 3'b010;
            PART_EXT:   m = 3'b100;
            PART_WHOLE: m = 3'b111;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/pmove_legal.sv
module pmove_legal
    import pmove_pkg::*;
#(
    parameter int unsigned AMODE_W     = 3,
    parameter int unsigned AM_LONG_ABS = 6,
    parameter int unsigned AM_LONG_IMM = 7
) (
    input  logic               class2_i,
    input  logic               acc_src_i,
    input  logic               ystore_i,
    input  logic [1:0]         ygrp_i,
    input  logic [AMODE_W-1:0] amode_i,
    input  logic [1:0]         alu_dst_i,
    output logic               illegal_o
);

    logic long_abs, long_imm;

    assign long_abs = (amode_i == AMODE_W'(AM_LONG_ABS));
    assign long_imm = (amode_i == AMODE_W'(AM_LONG_IMM));

    always_comb begin
        illegal_o = 1'b0;
        if (class2_i) begin
            illegal_o = long_abs || long_imm || alu_dst_i[acc_src_i];
        end else begin
            illegal_o = (ygrp_i == GRP_BAD)
                     || (ystore_i && long_imm)
                     || (!ystore_i && ygrp_i == GRP_ACCA && alu_dst_i[0])
                     || (!ystore_i && ygrp_i == GRP_ACCB && alu_dst_i[1]);
        end
    end

endmodule

// File: rtl/pmove_ctrl.sv
module pmove_ctrl
    import pmove_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic issue_i,
    input  logic illegal_i,
    output logic cap_o,
    output logic fetch_o,
    output logic commit_o,
    output logic fault_o
);

    pm_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (issue_i) state_d = illegal_i ? ST_FAULT : ST_FETCH;
            ST_FETCH:  state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_IDLE;
            ST_FAULT:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        cap_o    = 1'b0;
        fetch_o  = 1'b0;
        commit_o = 1'b0;
        fault_o  = 1'b0;
        unique case (state_q)
            ST_IDLE:   cap_o    = issue_i;
            ST_FETCH:  fetch_o  = 1'b1;
            ST_COMMIT: commit_o = 1'b1;
            ST_FAULT:  fault_o  = 1'b1;
        endcase
    end

    // R2
    fetch_to_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_o |=> commit_o);

    // R9
    fault_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |=> !fault_o && !fetch_o && !commit_o);

    // R13
    busy_no_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_o || commit_o) |=> !fetch_o || $past(cap_o));

endmodule

// File: rtl/pmove_route.sv
module pmove_route
    import pmove_pkg::*;
#(
    parameter int unsigned DW          = 24,
    parameter int unsigned EXT_W       = 8,
    parameter int unsigned AW          = 16,
    parameter int unsigned AMODE_W     = 3,
    parameter int unsigned AM_LONG_IMM = 7
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cap_i,
    input  logic                   fetch_i,
    input  logic                   commit_i,
    input  logic                   class2_i,
    input  logic                   acc_src_i,
    input  logic [1:0]             ireg_dst_i,
    input  logic                   ystore_i,
    input  logic [3:0]             yreg_i,
    input  logic [AMODE_W-1:0]     amode_i,
    input  logic [AW-1:0]          ea_i,
    input  logic [DW-1:0]          imm_i,
    input  logic [DW-1:0]          x0_i,
    input  logic [DW-1:0]          x1_i,
    input  logic [DW-1:0]          y0_i,
    input  logic [DW-1:0]          y1_i,
    input  logic [EXT_W+2*DW-1:0]  acc_a_i,
    input  logic [EXT_W+2*DW-1:0]  acc_b_i,
    input  logic [DW-1:0]          y_rdata_i,
    output logic [3:0]             ireg_we_o,
    output logic [4*DW-1:0]        ireg_wdata_o,
    output logic [1:0]             acc_we_o,
    output logic [2:0]             acc_part_o,
    output logic [EXT_W+2*DW-1:0]  acc_wdata_o,
    output logic                   y_re_o,
    output logic                   y_we_o,
    output logic [AW-1:0]          y_addr_o,
    output logic [DW-1:0]          y_wdata_o
);

    localparam int unsigned ACC_W  = EXT_W + 2 * DW;
    localparam int unsigned NIREG  = 4;

    logic              cls2_q, src_q, yst_q, immsel_q;
    logic [1:0]        idst_q;
    logic [3:0]        yreg_q;
    logic [AW-1:0]     ea_q;
    logic [DW-1:0]     imm_q, s1_hi_q, st_word_q, y0_q;
    logic [ACC_W-1:0]  s1_acc, rd_acc;
    logic [DW-1:0]     rd_word, ld_word;

    function automatic logic [ACC_W-1:0] place(input logic [DW-1:0] w, input logic [1:0] part);
        logic [ACC_W-1:0] r;
        unique case (part)
            PART_LO:    r = {{(ACC_W-DW){1'b0}}, w};
            PART_HI:    r = {{EXT_W{1'b0}}, w, {DW{1'b0}}};
            PART_EXT:   r = {w[EXT_W-1:0], {(2*DW){1'b0}}};
            PART_WHOLE: r = {{EXT_W{w[DW-1]}}, w, {DW{1'b0}}};
        endcase
        return r;
    endfunction

    // Source words are picked from the live register file at issue
    assign s1_acc = acc_src_i ? acc_b_i : acc_a_i;
    assign rd_acc = (yreg_i[3:2] == GRP_ACCB) ? acc_b_i : acc_a_i;

    always_comb begin
        rd_word = '0;
        if (yreg_i[3:2] == GRP_IREG) begin
            unique case (yreg_i[1:0])
                2'd0: rd_word = x0_i;
                2'd1: rd_word = x1_i;
                2'd2: rd_word = y0_i;
                2'd3: rd_word = y1_i;
            endcase
        end else if (yreg_i[3:2] != GRP_BAD) begin
            unique case (yreg_i[1:0])
                PART_LO:    rd_word = rd_acc[DW-1:0];
                PART_HI:    rd_word = rd_acc[2*DW-1:DW];
                PART_EXT:   rd_word = {{(DW-EXT_W){rd_acc[ACC_W-1]}}, rd_acc[ACC_W-1 -: EXT_W]};
                PART_WHOLE: rd_word = rd_acc[2*DW-1:DW];
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cls2_q    <= 1'b0;
            src_q     <= 1'b0;
            yst_q     <= 1'b0;
            immsel_q  <= 1'b0;
            idst_q    <= '0;
            yreg_q    <= '0;
            ea_q      <= '0;
            imm_q     <= '0;
            s1_hi_q   <= '0;
            st_word_q <= '0;
            y0_q      <= '0;
        end else if (cap_i) begin
            cls2_q    <= class2_i;
            src_q     <= acc_src_i;
            yst_q     <= ystore_i;
            immsel_q  <= (amode_i == AMODE_W'(AM_LONG_IMM));
            idst_q    <= ireg_dst_i;
            yreg_q    <= yreg_i;
            ea_q      <= ea_i;
            imm_q     <= imm_i;
            s1_hi_q   <= s1_acc[2*DW-1:DW];
            st_word_q <= rd_word;
            y0_q      <= y0_i;
        end
    end

    assign ld_word  = immsel_q ? imm_q : y_rdata_i;
    assign y_addr_o = ea_q;
    assign y_re_o   = fetch_i && !cls2_q && !yst_q && !immsel_q;

    for (genvar i = 0; i < NIREG; i++) begin : g_slot
        assign ireg_wdata_o[i*DW +: DW] =
            (!cls2_q && !yst_q && yreg_q[3:2] == GRP_IREG && yreg_q[1:0] == 2'(i))
            ? ld_word : s1_hi_q;
    end

    always_comb begin
        ireg_we_o   = '0;
        acc_we_o    = '0;
        acc_part_o  = '0;
        acc_wdata_o = '0;
        y_we_o      = 1'b0;
        y_wdata_o   = st_word_q;
        if (commit_i) begin
            if (cls2_q) begin
                y_we_o          = 1'b1;
                y_wdata_o       = s1_hi_q;
                acc_we_o[src_q] = 1'b1;
                acc_part_o      = 3'b111;
                acc_wdata_o     = place(y0_q, PART_WHOLE);
            end else begin
                ireg_we_o[idst_q] = 1'b1;
                if (yst_q) begin
                    y_we_o = 1'b1;
                end else begin
                    unique case (yreg_q[3:2])
                        GRP_IREG: ireg_we_o[yreg_q[1:0]] = 1'b1;
                        GRP_ACCA: begin
                            acc_we_o[0] = 1'b1;
                            acc_part_o  = part_mask(yreg_q[1:0]);
                            acc_wdata_o = place(ld_word, yreg_q[1:0]);
                        end
                        GRP_ACCB: begin
                            acc_we_o[1] = 1'b1;
                            acc_part_o  = part_mask(yreg_q[1:0]);
                            acc_wdata_o = place(ld_word, yreg_q[1:0]);
                        end
                        GRP_BAD: ;
                    endcase
                end
            end
        end
    end

    // R10
    acc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(acc_we_o) && ((acc_we_o == '0) == (acc_part_o == '0)));

    // R3
    mem_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(y_re_o && y_we_o));

    // R2
    read_then_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        y_re_o |=> commit_i && $stable(y_addr_o));

endmodule

// File: rtl/pmove_unit.sv
module pmove_unit
    import pmove_pkg::*;
#(
    parameter int unsigned DW          = 24,
    parameter int unsigned EXT_W       = 8,
    parameter int unsigned AW          = 16,
    parameter int unsigned AMODE_W     = 3,
    parameter int unsigned AM_LONG_ABS = 6,
    parameter int unsigned AM_LONG_IMM = 7
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   issue_i,
    input  logic                   class2_i,
    input  logic                   acc_src_i,
    input  logic [1:0]             ireg_dst_i,
    input  logic                   ystore_i,
    input  logic [3:0]             yreg_i,
    input  logic [AMODE_W-1:0]     amode_i,
    input  logic [AW-1:0]          ea_i,
    input  logic [DW-1:0]          imm_i,
    input  logic [1:0]             alu_dst_i,
    input  logic [DW-1:0]          x0_i,
    input  logic [DW-1:0]          x1_i,
    input  logic [DW-1:0]          y0_i,
    input  logic [DW-1:0]          y1_i,
    input  logic [EXT_W+2*DW-1:0]  acc_a_i,
    input  logic [EXT_W+2*DW-1:0]  acc_b_i,
    input  logic [DW-1:0]          y_rdata_i,
    output logic [3:0]             ireg_we_o,
    output logic [4*DW-1:0]        ireg_wdata_o,
    output logic [1:0]             acc_we_o,
    output logic [2:0]             acc_part_o,
    output logic [EXT_W+2*DW-1:0]  acc_wdata_o,
    output logic                   y_re_o,
    output logic                   y_we_o,
    output logic [AW-1:0]          y_addr_o,
    output logic [DW-1:0]          y_wdata_o,
    output logic                   illegal_o
);

    logic illegal_w, cap_w, fetch_w, commit_w, fault_w;

    pmove_legal #(
        .AMODE_W(AMODE_W), .AM_LONG_ABS(AM_LONG_ABS), .AM_LONG_IMM(AM_LONG_IMM)
    ) u_legal (
        .class2_i(class2_i), .acc_src_i(acc_src_i), .ystore_i(ystore_i),
        .ygrp_i(yreg_i[3:2]), .amode_i(amode_i), .alu_dst_i(alu_dst_i),
        .illegal_o(illegal_w)
    );

    pmove_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .illegal_i(illegal_w),
        .cap_o(cap_w), .fetch_o(fetch_w), .commit_o(commit_w), .fault_o(fault_w)
    );

    pmove_route #(
        .DW(DW), .EXT_W(EXT_W), .AW(AW), .AMODE_W(AMODE_W), .AM_LONG_IMM(AM_LONG_IMM)
    ) u_route (
        .clk(clk), .rst_n(rst_n), .cap_i(cap_w), .fetch_i(fetch_w), .commit_i(commit_w),
        .class2_i(class2_i), .acc_src_i(acc_src_i), .ireg_dst_i(ireg_dst_i),
        .ystore_i(ystore_i), .yreg_i(yreg_i), .amode_i(amode_i), .ea_i(ea_i),
        .imm_i(imm_i), .x0_i(x0_i), .x1_i(x1_i), .y0_i(y0_i), .y1_i(y1_i),
        .acc_a_i(acc_a_i), .acc_b_i(acc_b_i), .y_rdata_i(y_rdata_i),
        .ireg_we_o(ireg_we_o), .ireg_wdata_o(ireg_wdata_o), .acc_we_o(acc_we_o),
        .acc_part_o(acc_part_o), .acc_wdata_o(acc_wdata_o), .y_re_o(y_re_o),
        .y_we_o(y_we_o), .y_addr_o(y_addr_o), .y_wdata_o(y_wdata_o)
    );

    assign illegal_o = fault_w;

    // R9
    fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (!y_we_o && !y_re_o && ireg_we_o == '0 && acc_we_o == '0));

    // R7
    long_mode_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_w && class2_i && (amode_i == AMODE_W'(AM_LONG_ABS) || amode_i == AMODE_W'(AM_LONG_IMM)))
        |=> illegal_o);

    // R8
    dup_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_w && ((class2_i && alu_dst_i[acc_src_i])
                || (!class2_i && !ystore_i && yreg_i[3:2] == GRP_ACCA && alu_dst_i[0])
                || (!class2_i && !ystore_i && yreg_i[3:2] == GRP_ACCB && alu_dst_i[1])))
        |=> illegal_o);

    // R11
    bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_w && !class2_i && yreg_i[3:2] == GRP_BAD) |=> illegal_o);

endmodule

// File: tb/tb_pmove_unit.sv
module tb_pmove_unit;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic        issue, cls2, src, yst;
    logic [1:0]  idst, alu;
    logic [3:0]  yreg;
    logic [2:0]  am;
    logic [7:0]  ea;
    logic [23:0] imm;

    logic [23:0] xr [4];
    logic [55:0] aa, bb;
    logic [23:0] mem [256];
    logic [23:0] rdata;

    logic [3:0]  ireg_we;
    logic [95:0] ireg_wdata;
    logic [1:0]  acc_we;
    logic [2:0]  acc_part;
    logic [55:0] acc_wdata;
    logic        y_re, y_we, illegal;
    logic [7:0]  y_addr;
    logic [23:0] y_wdata;

    int n_chk = 0, n_bad = 0;
    int rd_n = 0, yw_n = 0, rw_n = 0, ill_n = 0;
    int rd0, yw0, rw0, ill0;

    pmove_unit #(.AW(8)) dut (
        .clk(clk), .rst_n(rst_n), .issue_i(issue), .class2_i(cls2), .acc_src_i(src),
        .ireg_dst_i(idst), .ystore_i(yst), .yreg_i(yreg), .amode_i(am), .ea_i(ea),
        .imm_i(imm), .alu_dst_i(alu), .x0_i(xr[0]), .x1_i(xr[1]), .y0_i(xr[2]),
        .y1_i(xr[3]), .acc_a_i(aa), .acc_b_i(bb), .y_rdata_i(rdata),
        .ireg_we_o(ireg_we), .ireg_wdata_o(ireg_wdata), .acc_we_o(acc_we),
        .acc_part_o(acc_part), .acc_wdata_o(acc_wdata), .y_re_o(y_re), .y_we_o(y_we),
        .y_addr_o(y_addr), .y_wdata_o(y_wdata), .illegal_o(illegal)
    );

    function automatic logic [23:0] mseed(input logic [7:0] a);
        return {8'h5A, a, ~a};
    endfunction

    function automatic logic [55:0] merge(input logic [55:0] old, input logic [55:0] d,
                                          input logic [2:0] p);
        logic [55:0] r = old;
        if (p[0]) r[23:0]  = d[23:0];
        if (p[1]) r[47:24] = d[47:24];
        if (p[2]) r[55:48] = d[55:48];
        return r;
    endfunction

    // register file and Y memory model driven by the unit's write ports
    always @(posedge clk) begin
        if (!rst_n) begin
            xr[0] <= 24'h111111; xr[1] <= 24'h222222;
            xr[2] <= 24'h876543; xr[3] <= 24'h444444;
            aa <= 56'h80_ABCDEF_123456;
            bb <= 56'h01_765432_0FEDCB;
            rdata <= '0;
            for (int i = 0; i < 256; i++) mem[i] <= mseed(8'(i));
        end else begin
            if (y_re) begin rdata <= mem[y_addr]; rd_n <= rd_n + 1; end
            if (y_we) begin mem[y_addr] <= y_wdata; yw_n <= yw_n + 1; end
            for (int i = 0; i < 4; i++)
                if (ireg_we[i]) xr[i] <= ireg_wdata[i*24 +: 24];
            if (acc_we[0]) aa <= merge(aa, acc_wdata, acc_part);
            if (acc_we[1]) bb <= merge(bb, acc_wdata, acc_part);
            if (ireg_we != 0 || acc_we != 0) rw_n <= rw_n + 1;
            if (illegal) ill_n <= ill_n + 1;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic c2, input logic s, input logic [1:0] d1, input logic st,
                         input logic [3:0] yr, input logic [2:0] amv, input logic [7:0] eav,
                         input logic [23:0] iv, input logic [1:0] al);
        cls2 = c2; src = s; idst = d1; yst = st; yreg = yr;
        am = amv; ea = eav; imm = iv; alu = al;
    endtask

    task automatic run(input logic c2, input logic s, input logic [1:0] d1, input logic st,
                       input logic [3:0] yr, input logic [2:0] amv, input logic [7:0] eav,
                       input logic [23:0] iv, input logic [1:0] al);
        @(negedge clk);
        rd0 = rd_n; yw0 = yw_n; rw0 = rw_n; ill0 = ill_n;
        drive(c2, s, d1, st, yr, amv, eav, iv, al);
        issue = 1'b1;
        @(negedge clk);
        issue = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R14 write enables", {ireg_we, acc_we, y_we}, 0);
        chk("R14 read strobe", y_re, 0);
        chk("R14 illegal flag", illegal, 0);
    endtask

    task automatic t_class1_load;
        run(0, 0, 2'd1, 0, 4'b0010, 3'd0, 8'h10, 0, 2'b00);
        chk("R1 X1 from A high", xr[1], 24'hABCDEF);
        chk("R2 Y0 from memory", xr[2], mseed(8'h10));
        chk("R2 one read", rd_n - rd0, 1);
    endtask

    task automatic t_class1_store;
        run(0, 1, 2'd0, 1, 4'b0001, 3'd1, 8'h20, 0, 2'b00);
        chk("R1 next instr sees X1", mem[8'h20], 24'hABCDEF);
        chk("R1 X0 from B high", xr[0], 24'h765432);
        chk("R3 no read on store", rd_n - rd0, 0);
        run(0, 0, 2'd3, 1, 4'b0110, 3'd6, 8'h21, 0, 2'b01);
        chk("R3 ext sign-extended", mem[8'h21], 24'hFFFF80);
        chk("R5 long absolute legal", ill_n - ill0, 0);
        chk("R8 store from ALU acc legal", xr[3], 24'hABCDEF);
    endtask

    task automatic t_immediate;
        run(0, 0, 2'd2, 0, 4'b1011, 3'd7, 8'h30, 24'h800001, 2'b01);
        chk("R10 whole B fill", bb, 56'hFF_800001_000000);
        chk("R4 no read on immediate", rd_n - rd0, 0);
        chk("R4 memory untouched", mem[8'h30], mseed(8'h30));
        run(0, 0, 2'd0, 1, 4'b0000, 3'd7, 8'h50, 0, 2'b00);
        chk("R4 immediate store illegal", ill_n - ill0, 1);
        chk("R9 no memory write", yw_n - yw0, 0);
        chk("R9 X0 unchanged", xr[0], 24'h765432);
    endtask

    task automatic t_part_write;
        run(0, 1, 2'd0, 0, 4'b0100, 3'd2, 8'h40, 0, 2'b10);
        chk("R10 A low part only", aa, {32'h80_ABCDEF, mseed(8'h40)});
        chk("R1 X0 from new B high", xr[0], 24'h800001);
    endtask

    task automatic t_duplicate;
        run(0, 0, 2'd0, 0, 4'b0101, 3'd0, 8'h60, 0, 2'b01);
        chk("R8 A high dest illegal", ill_n - ill0, 1);
        chk("R9 A unchanged", aa, {32'h80_ABCDEF, mseed(8'h40)});
        chk("R9 no read", rd_n - rd0, 0);
        chk("R9 X0 unchanged", xr[0], 24'h800001);
        run(0, 0, 2'd1, 0, 4'b1011, 3'd0, 8'h60, 0, 2'b10);
        chk("R8 whole B dest illegal", ill_n - ill0, 1);
        chk("R8 B unchanged", bb, 56'hFF_800001_000000);
        run(0, 0, 2'd0, 0, 4'b1010, 3'd0, 8'h61, 0, 2'b01);
        chk("R8 other acc legal", ill_n - ill0, 0);
        chk("R10 B ext from low byte", bb, 56'h9E_800001_000000);
        run(0, 0, 2'd1, 0, 4'b1100, 3'd0, 8'h62, 0, 2'b00);
        chk("R11 bad code illegal", ill_n - ill0, 1);
        chk("R11 no write", (rw_n - rw0) + (rd_n - rd0), 0);
    endtask

    task automatic t_class2;
        run(1, 1, 2'd0, 0, 4'b0000, 3'd5, 8'h70, 0, 2'b01);
        chk("R6 old B high stored", mem[8'h70], 24'h800001);
        chk("R6 B loaded from Y0", bb, 56'hFF_ABCDEF_000000);
        chk("R5 short absolute legal", ill_n - ill0, 0);
        run(1, 0, 2'd0, 0, 4'b0000, 3'd6, 8'h71, 0, 2'b00);
        chk("R7 long absolute illegal", ill_n - ill0, 1);
        chk("R7 memory untouched", mem[8'h71], mseed(8'h71));
        run(1, 0, 2'd0, 0, 4'b0000, 3'd7, 8'h72, 0, 2'b00);
        chk("R7 long immediate illegal", ill_n - ill0, 1);
        run(1, 0, 2'd0, 0, 4'b0000, 3'd0, 8'h73, 0, 2'b01);
        chk("R8 class II dup illegal", ill_n - ill0, 1);
        chk("R9 A unchanged", aa, {32'h80_ABCDEF, mseed(8'h40)});
    endtask

    task automatic t_collision;
        run(0, 0, 2'd0, 0, 4'b0000, 3'd3, 8'h11, 0, 2'b00);
        chk("R12 Y-side wins", xr[0], mseed(8'h11));
    endtask

    task automatic t_busy;
        @(negedge clk);
        rd0 = rd_n;
        drive(0, 1, 2'd3, 0, 4'b0010, 3'd0, 8'h12, 0, 2'b00);
        issue = 1'b1;
        @(negedge clk);
        drive(0, 1, 2'd1, 0, 4'b0011, 3'd0, 8'h13, 0, 2'b00);
        @(negedge clk);
        issue = 1'b0;
        repeat (3) @(negedge clk);
        chk("R13 first executed Y0", xr[2], mseed(8'h12));
        chk("R13 second ignored Y1", xr[3], 24'hABCDEF);
        chk("R13 single read", rd_n - rd0, 1);
    endtask

    initial begin
        issue = 1'b0;
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_class1_load();
        t_class1_store();
        t_immediate();
        t_part_write();
        t_duplicate();
        t_class2();
        t_collision();
        t_busy();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule